// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

This block copies a region of memory to another address, one fixed-size beat at a time. A start pulse captures four staged values: a configuration word, a byte count, a source address and a destination address. In the cycle after the pulse the engine decides whether the request is legal. An illegal request raises the error flag at once and touches no memory. A legal request clears both status flags and loads the live working registers from the captured values. The engine then alternates between a read request, a read response and a write request until the count is used up.

The beat length is taken from two 4-bit size codes in the configuration word, one for reads and one for writes. Each code is the log2 of the byte count. The two codes must match, and any code above the largest supported value is treated as that value. The working registers stay visible on the ports while the copy runs. If the repeat bit is set, they return to their starting values once the copy is finished.

Top module: `dma_copy_engine`

## Requirements
- R1: After reset `busy`, `done` and `err` are 0, no request valid is high, and `exec_cfg`, `exec_bytes`, `exec_src` and `exec_dst` are 0.
- R2: A start with a byte count of 0 sets `err`, issues no read or write request, and leaves `done` and the exec registers unchanged.
- R3: A start whose read size code (config bits [31:28]) differs from its write size code (config bits [27:24]) is an error, handled as in R2.
- R4: A size code above 6 is treated as 6. The beat length is 2^code bytes (64 at most), and `rd_req_size`/`wr_req_size` carry the clamped code.
- R5: A start whose byte count is not an exact multiple of the beat length is an error, handled as in R2.
- R6: A legal start clears `done` and `err` and loads the exec registers from the captured configuration, count, source and destination. These values are visible two clock edges after the edge that samples `start`.
- R7: Each beat reads from `exec_src`, then writes the returned bytes to `exec_dst`. Write strobe bit i is set exactly when i is less than the beat length, and data bytes outside the beat are 0. After each accepted write, both addresses advance by the beat length and `exec_bytes` falls by the same amount.
- R8: At most one request is outstanding. A read and a write request are never valid together, and no write is issued before the read response for that beat has arrived.
- R9: After the last write is accepted, `busy` falls and `done` rises. With repeat clear, `exec_bytes` ends at 0 and both addresses end one full length past their starting values.
- R10: With config bit 2 (repeat) set, completion restores `exec_bytes`, `exec_src` and `exec_dst` to their starting values.
- R11: A `start` pulse while `busy` is high is ignored.
- R12: A request valid, once raised, stays high with a stable address until its ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, sampled while idle |
| start_cfg | input | 32 | Staged configuration word |
| start_bytes | input | LEN_W | Staged byte count |
| start_src | input | ADDR_W | Staged source address |
| start_dst | input | ADDR_W | Staged destination address |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read address |
| rd_req_size | output | CODE_W | Clamped log2 beat size |
| rd_resp_valid | input | 1 | Read data returned |
| rd_resp_data | input | 8*2^MAX_CODE | Read data, beat in the low bytes |
| wr_req_valid | output | 1 | Write request valid |
| wr_req_ready | input | 1 | Write request accepted |
| wr_req_addr | output | ADDR_W | Write address |
| wr_req_size | output | CODE_W | Clamped log2 beat size |
| wr_req_data | output | 8*2^MAX_CODE | Write data, zero outside the beat |
| wr_req_strb | output | 2^MAX_CODE | Byte enables |
| busy | output | 1 | Copy in progress |
| done | output | 1 | Last copy completed |
| err | output | 1 | Last start was rejected |
| exec_cfg | output | 32 | Working configuration |
| exec_bytes | output | LEN_W | Remaining byte count |
| exec_src | output | ADDR_W | Current source address |
| exec_dst | output | ADDR_W | Current destination address |

## Verification
The hardest case to reach from the ports is a second start request that arrives while a copy is under way. It must be captured by nothing, yet it has to land while the engine is still waiting on a handshake. The bench stalls both ready signals with a cycle-based pattern so that a multi-beat copy stays busy for a long time. It then pulses start with entirely different parameters partway through and checks that the final addresses, the count and the beat data all match the first request. The clamped 64-byte beat, with every strobe bit set, is driven through the same stalled path in repeat mode.

// File: rtl/dma_copy_engine.sv
`timescale 1ns/1ps
module dma_copy_engine #(
  parameter int ADDR_W   = 64,
  parameter int LEN_W    = 32,
  parameter int MAX_CODE = 6,
  localparam int CODE_W    = $clog2(MAX_CODE + 1),
  localparam int BUS_BYTES = 1 << MAX_CODE,
  localparam int BUS_W     = 8 * BUS_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       start_cfg,
  input  logic [LEN_W-1:0]  start_bytes,
  input  logic [ADDR_W-1:0] start_src,
  input  logic [ADDR_W-1:0] start_dst,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  output logic [CODE_W-1:0] rd_req_size,
  input  logic              rd_resp_valid,
  input  logic [BUS_W-1:0]  rd_resp_data,
  output logic              wr_req_valid,
  input  logic              wr_req_ready,
  output logic [ADDR_W-1:0] wr_req_addr,
  output logic [CODE_W-1:0] wr_req_size,
  output logic [BUS_W-1:0]  wr_req_data,
  output logic [BUS_BYTES-1:0] wr_req_strb,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [31:0]       exec_cfg,
  output logic [LEN_W-1:0]  exec_bytes,
  output logic [ADDR_W-1:0] exec_src,
  output logic [ADDR_W-1:0] exec_dst
);
  localparam int WSZ_LSB = 24;
  localparam int RSZ_LSB = 28;
  localparam int REPEAT_BIT = 2;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_RDREQ, S_RDWAIT, S_WRREQ} state_t;
  state_t state;

  logic [31:0]       snap_cfg;
  logic [LEN_W-1:0]  snap_bytes;
  logic [ADDR_W-1:0] snap_src, snap_dst;
  logic [CODE_W-1:0] code_q;
  logic [BUS_W-1:0]  beat_buf;

  wire [3:0] wsz = snap_cfg[WSZ_LSB +: 4];
  wire [3:0] rsz = snap_cfg[RSZ_LSB +: 4];
  wire [CODE_W-1:0] chk_code = (wsz > 4'(MAX_CODE)) ? CODE_W'(MAX_CODE) : wsz[CODE_W-1:0];
  wire [LEN_W-1:0]  chk_beat = LEN_W'(1) << chk_code;
  wire legal = (snap_bytes != '0) && (wsz == rsz) && ((snap_bytes & (chk_beat - LEN_W'(1))) == '0);

  wire [LEN_W-1:0]  beat_len  = LEN_W'(1) << code_q;
  wire [ADDR_W-1:0] beat_step = ADDR_W'(beat_len);
  wire [BUS_BYTES-1:0] byte_mask = ~({BUS_BYTES{1'b1}} << beat_len);
  wire last_beat = (exec_bytes == beat_len);

  assign busy         = (state != S_IDLE);
  assign rd_req_valid = (state == S_RDREQ);
  assign wr_req_valid = (state == S_WRREQ);
  assign rd_req_addr  = exec_src;
  assign wr_req_addr  = exec_dst;
  assign rd_req_size  = code_q;
  assign wr_req_size  = code_q;
  assign wr_req_strb  = byte_mask;

  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
    assign wr_req_data[8*i +: 8] = byte_mask[i] ? beat_buf[8*i +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      snap_cfg   <= '0;
      snap_bytes <= '0;
      snap_src   <= '0;
      snap_dst   <= '0;
      code_q     <= '0;
      beat_buf   <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
      exec_cfg   <= '0;
      exec_bytes <= '0;
      exec_src   <= '0;
      exec_dst   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          snap_cfg   <= start_cfg;
          snap_bytes <= start_bytes;
          snap_src   <= start_src;
          snap_dst   <= start_dst;
          state      <= S_CHECK;
        end
        S_CHECK: if (!legal) begin
          err   <= 1'b1;
          state <= S_IDLE;
        end else begin
          done       <= 1'b0;
          err        <= 1'b0;
          code_q     <= chk_code;
          exec_cfg   <= snap_cfg;
          exec_bytes <= snap_bytes;
          exec_src   <= snap_src;
          exec_dst   <= snap_dst;
          state      <= S_RDREQ;
        end
        S_RDREQ: if (rd_req_ready) state <= S_RDWAIT;
        S_RDWAIT: if (rd_resp_valid) begin
          beat_buf <= rd_resp_data;
          state    <= S_WRREQ;
        end
        S_WRREQ: if (wr_req_ready) begin
          if (last_beat) begin
            done  <= 1'b1;
            state <= S_IDLE;
            if (snap_cfg[REPEAT_BIT]) begin
              exec_bytes <= snap_bytes;
              exec_src   <= snap_src;
              exec_dst   <= snap_dst;
            end else begin
              exec_bytes <= '0;
              exec_src   <= exec_src + beat_step;
              exec_dst   <= exec_dst + beat_step;
            end
          end else begin
            exec_bytes <= exec_bytes - beat_len;
            exec_src   <= exec_src + beat_step;
            exec_dst   <= exec_dst + beat_step;
            state      <= S_RDREQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_copy_engine_chk.sv
`timescale 1ns/1ps
module dma_copy_engine_chk #(
  parameter int ADDR_W   = 64,
  parameter int MAX_CODE = 6,
  localparam int CODE_W    = $clog2(MAX_CODE + 1),
  localparam int BUS_BYTES = 1 << MAX_CODE
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              wr_req_valid,
  input logic              wr_req_ready,
  input logic [ADDR_W-1:0] wr_req_addr,
  input logic [CODE_W-1:0] wr_req_size,
  input logic [BUS_BYTES-1:0] wr_req_strb,
  input logic              busy,
  input logic              done,
  input logic              err
);
  // R8
  one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && wr_req_valid));
  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));
  // R12
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_valid && !wr_req_ready |=> wr_req_valid && $stable(wr_req_addr));
  // R7
  strobe_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_valid |-> ($countones(wr_req_strb) == (1 << wr_req_size)) && wr_req_strb[0]);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy && !rd_req_valid && !wr_req_valid);
  // R2
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy && !rd_req_valid && !wr_req_valid);
endmodule

bind dma_copy_engine dma_copy_engine_chk #(.ADDR_W(ADDR_W), .MAX_CODE(MAX_CODE)) u_chk (.*);

// File: tb/dma_copy_engine_bench.sv
`timescale 1ns/1ps
module dma_copy_engine_bench;
  localparam int AW = 64, LW = 32, MC = 6, BB = 64, BW = 512, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start = 1'b0;
  logic [31:0] start_cfg = '0;
  logic [LW-1:0] start_bytes = '0;
  logic [AW-1:0] start_src = '0, start_dst = '0;
  logic rd_req_valid, rd_req_ready, rd_resp_valid, wr_req_valid, wr_req_ready;
  logic [AW-1:0] rd_req_addr, wr_req_addr;
  logic [CW-1:0] rd_req_size, wr_req_size;
  logic [BW-1:0] rd_resp_data, wr_req_data;
  logic [BB-1:0] wr_req_strb;
  logic busy, done, err;
  logic [31:0] exec_cfg;
  logic [LW-1:0] exec_bytes;
  logic [AW-1:0] exec_src, exec_dst;

  dma_copy_engine u_dma_copy_engine (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_rd = 0, n_wr = 0, beat_errs = 0, overlap = 0, hold_errs = 0, early_wr = 0;
  int exp_beat = 1, w_base = 0, pend = 0;
  logic [AW-1:0] exp_src = '0, exp_dst = '0;
  logic [CW-1:0] last_rd_size = '0;
  logic stall_en = 1'b0;
  logic prev_rv = 1'b0, prev_rr = 1'b0, prev_wv = 1'b0, prev_wr = 1'b0;

  assign rd_req_ready = !stall_en || cyc[0];
  assign wr_req_ready = !stall_en || (cyc[1] && cyc[0]);

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [BB-1:0] mk(input int b);
    return (b >= BB) ? '1 : ((BB'(1) << b) - BB'(1));
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      rd_resp_valid <= 1'b0;
      rd_resp_data  <= '0;
    end else begin
      if (rd_req_valid && wr_req_valid) overlap = overlap + 1;
      if (prev_rv && !prev_rr && !rd_req_valid) hold_errs = hold_errs + 1;
      if (prev_wv && !prev_wr && !wr_req_valid) hold_errs = hold_errs + 1;
      if (wr_req_valid && pend == 0) early_wr = early_wr + 1;
      if (rd_resp_valid) pend = 1;
      if (rd_req_valid && rd_req_ready) begin
        n_rd = n_rd + 1;
        last_rd_size = rd_req_size;
        rd_resp_valid <= 1'b1;
        for (int i = 0; i < BB; i++) rd_resp_data[8*i +: 8] <= pat(rd_req_addr + AW'(i));
      end else begin
        rd_resp_valid <= 1'b0;
      end
      if (wr_req_valid && wr_req_ready) begin
        pend = 0;
        if (wr_req_addr != exp_dst + AW'((n_wr - w_base) * exp_beat)) beat_errs = beat_errs + 1;
        if (wr_req_strb != mk(exp_beat)) beat_errs = beat_errs + 1;
        for (int i = 0; i < BB; i++) begin
          if (wr_req_data[8*i +: 8] !=
              ((i < exp_beat) ? pat(exp_src + (wr_req_addr - exp_dst) + AW'(i)) : 8'h00))
            beat_errs = beat_errs + 1;
        end
        n_wr = n_wr + 1;
      end
      prev_rv <= rd_req_valid; prev_rr <= rd_req_ready;
      prev_wv <= wr_req_valid; prev_wr <= wr_req_ready;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic kick(input logic [31:0] cfg, input logic [LW-1:0] b, input logic [AW-1:0] s, input logic [AW-1:0] d);
    @(negedge clk);
    start = 1'b1; start_cfg = cfg; start_bytes = b; start_src = s; start_dst = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
  endtask

  function automatic logic [31:0] mkcfg(input int rc, input int wc, input bit rep);
    return (32'(rc) << 28) | (32'(wc) << 24) | (rep ? 32'h4 : 32'h0);
  endfunction

  task automatic t_reset();
    chk(!busy && !done && !err, "R1 flags after reset", {busy, done, err}, 0);
    chk(!rd_req_valid && !wr_req_valid, "R1 no requests after reset", {rd_req_valid, wr_req_valid}, 0);
    chk(exec_bytes == 0 && exec_src == 0 && exec_dst == 0 && exec_cfg == 0, "R1 exec regs zero",
        exec_src, 0);
  endtask

  task automatic t_bad(input string tag, input logic [31:0] cfg, input logic [LW-1:0] b);
    int r0 = n_rd, w0 = n_wr;
    logic d0 = done;
    logic [LW-1:0] eb = exec_bytes;
    logic [AW-1:0] es = exec_src;
    kick(cfg, b, 64'h7000, 64'h8000);
    wait_idle();
    chk(err == 1'b1, {tag, " err set"}, err, 1);
    chk(n_rd == r0 && n_wr == w0, {tag, " no memory access"}, n_rd - r0 + n_wr - w0, 0);
    chk(done == d0, {tag, " done unchanged"}, done, d0);
    chk(exec_bytes == eb && exec_src == es, {tag, " exec regs unchanged"}, exec_src, es);
  endtask

  task automatic t_copy(input string tag, input int code, input logic [LW-1:0] b,
                        input logic [AW-1:0] s, input logic [AW-1:0] d, input bit rep, input bit stl,
                        input bit intrude);
    int r0, w0, e0, beats;
    logic [31:0] cfg = mkcfg(code, code, rep);
    exp_beat = 1 << ((code > MC) ? MC : code);
    beats = int'(b) / exp_beat;
    exp_src = s; exp_dst = d; w_base = n_wr; stall_en = stl;
    r0 = n_rd; w0 = n_wr; e0 = beat_errs;
    kick(cfg, b, s, d);
    @(negedge clk);
    chk(!done && !err, {tag, " R6 flags cleared"}, {done, err}, 0);
    chk(exec_cfg == cfg && exec_bytes == b, {tag, " R6 exec cfg/bytes loaded"}, exec_bytes, b);
    chk(exec_src == s && exec_dst == d, {tag, " R6 exec addrs loaded"}, exec_src, s);
    if (intrude) begin
      repeat (5) @(negedge clk);
      kick(mkcfg(0, 0, 1'b0), 32'd1, 64'hDEAD0, 64'hBEEF0);
    end
    wait_idle();
    chk(done && !err && !busy, {tag, " R9 done set"}, {done, err, busy}, 3'b100);
    chk(n_rd - r0 == beats && n_wr - w0 == beats, {tag, " R7 beat count"}, n_wr - w0, beats);
    chk(beat_errs == e0, {tag, " R7 beat data/strobe/address"}, beat_errs - e0, 0);
    chk(int'(last_rd_size) == ((code > MC) ? MC : code), {tag, " R4 clamped size code"}, last_rd_size,
        (code > MC) ? MC : code);
    if (rep) begin
      chk(exec_bytes == b && exec_src == s && exec_dst == d, {tag, " R10 repeat restore"}, exec_src, s);
    end else begin
      chk(exec_bytes == 0 && exec_src == s + AW'(b) && exec_dst == d + AW'(b),
          {tag, " R9 final exec regs"}, exec_dst, d + AW'(b));
    end
    stall_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL R9 watchdog expired actual=busy expected=idle");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bad("R2 zero length", mkcfg(2, 2, 1'b0), 32'd0);
    t_copy("code2 32B", 2, 32'd32, 64'h1000, 64'h2_0000_0000, 1'b0, 1'b0, 1'b0);
    t_bad("R3 size mismatch", mkcfg(3, 2, 1'b0), 32'd16);
    t_copy("R4 code9 clamp", 9, 32'd128, 64'h3040, 64'h5000, 1'b1, 1'b1, 1'b0);
    t_bad("R5 non-multiple", mkcfg(3, 3, 1'b0), 32'd12);
    t_copy("code0 3B", 0, 32'd3, 64'h1FF, 64'h9001, 1'b0, 1'b0, 1'b0);
    t_copy("R11 start while busy", 3, 32'd64, 64'hA000, 64'hC008, 1'b0, 1'b1, 1'b1);
    chk(overlap == 0 && early_wr == 0, "R8 single outstanding request", overlap + early_wr, 0);
    chk(hold_errs == 0, "R12 valid held until ready", hold_errs, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule